// File: doc/BRIEF.md
# Status Register Write Unit

This unit keeps the processor's current status word and one saved status word, and carries out the moves that write or read them. A write takes its operand from one of two places. It can come from a general register, which the unit addresses through a small read port. It can also come from an 8-bit immediate in the instruction word, rotated right. Two select bits in the instruction say which bytes of the status word the write may reach: the top byte or the bottom byte.

Not every bit in a selected byte can be written. In the top byte only the four condition flags can change. In the bottom byte the bits split into two groups: the state bit and the privileged control bits, which are the mode and the interrupt-disable bits. While the current mode is user, the privileged bits of the current word are protected, but the flags and the state bit are still written. Writes to the saved word are not guarded by privilege, and bit 4 of the stored value is always set. The unit presents the current mode directly. After every write to the current word it raises a single-cycle flush request, so the fetch stage can refill its two prefetch slots.

Requests are sampled on the rising clock edge. All results are registered and visible in the following cycle.

Top module: `psr_write_unit`

## Requirements
- R1: When reset is released, `cur_psr` is 0x000000D3, `saved_psr` is 0x00000010, `mode_out` is 0x13, and `flush_req` and `rd_valid` are 0.
- R2: With `req_imm`=1, the operand is `instr[7:0]` rotated right by twice `instr[11:8]`.
- R3: With `req_imm`=0, `src_idx` equals `instr[3:0]` and the operand is `src_data`.
- R4: In a write to the current word with `instr[19]`=1, only bits [31:28] take operand bits. Bits [27:8] never change on any write to the current word. When `instr[19]`=0, bits [31:28] keep their value.
- R5: In a write to the current word with `instr[16]`=1 outside user mode, bits 0x000000CF and bit 5 take operand bits and bit 4 keeps its value. When `instr[16]`=0, the whole bottom byte keeps its value.
- R6: In user mode (`cur_psr[4:0]`=0x10), a write to the current word leaves bits 0x000000CF unchanged. Bits [31:28] and bit 5 are still written when their byte is selected.
- R7: `mode_out` equals `cur_psr[4:0]`. After a privileged write with `instr[16]`=1 it becomes {1, operand[3:0]}.
- R8: A write to the saved word (`req_saved`=1) uses mask (byte select AND 0xF00000EF). Every such write sets bit 4 of the result to 1, in any mode.
- R9: A read (`req_write`=0) sets `rd_valid` for one cycle in the next cycle. It returns the whole selected word on `rd_data` and `instr[15:12]` on `rd_dest`, and neither register changes.
- R10: `flush_req` is 1 in the cycle after every write to the current word, even if no field is selected. It stays 0 after saved-word writes and after reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write (move into a status word), 0 = read |
| req_saved | input | 1 | 1 = target the saved word, 0 = the current word |
| req_imm | input | 1 | 1 = rotated-immediate operand, 0 = register operand |
| instr | input | 32 | Instruction word: [19] top-byte select, [16] bottom-byte select, [15:12] read destination, [11:8] rotate, [7:0] immediate, [3:0] source register |
| src_idx | output | 4 | Register index for the operand read |
| src_data | input | 32 | Value of the register named by `src_idx` |
| cur_psr | output | 32 | Current status word |
| saved_psr | output | 32 | Saved status word |
| mode_out | output | 5 | Current processor mode |
| flush_req | output | 1 | One-cycle prefetch refill request |
| rd_valid | output | 1 | Read result valid |
| rd_dest | output | 4 | Destination register of a read |
| rd_data | output | 32 | Value returned by a read |

## Verification
The bench targets the places where byte selects and protection masks cross.

- Top-byte write: a flags-only write must leave bits [27:24] alone. A design that applied the whole byte select would corrupt them.
- Odd rotate field: an immediate with an odd rotate field exposes a design that rotates by the field value instead of twice it.
- User-mode write: the bench drops into user mode and then writes both bytes. A design that failed to split the bottom byte would either lose the state bit or let the mode escape user mode.
- Saved-word writes: the bench writes the saved word with all ones and then with zero. A design without the forced bit 4 would clear it, and one that applied the full byte would set bits [27:24].
- Flush timing: the bench checks the flush on a write with no field selected, and checks that reads and saved-word writes raise none. A design that gated the flush on a non-empty mask would be caught.

// File: rtl/psr_pkg.sv
package psr_pkg;

   // Default protection groups of the status word
   localparam logic [31:0] FLAG_BITS_DEF  = 32'hF000_0000;
   localparam logic [31:0] PRIV_BITS_DEF  = 32'h0000_00CF;
   localparam logic [31:0] STATE_BITS_DEF = 32'h0000_0020;

   // Instruction field positions decoded by this unit
   localparam int TOP_SEL_POS  = 19;
   localparam int LOW_SEL_POS  = 16;
   localparam int DEST_LSB     = 12;
   localparam int ROT_LSB      = 8;
   localparam int IMM_LSB      = 0;
   localparam int SRC_LSB      = 0;

   typedef struct packed {
      logic top_sel;
      logic low_sel;
   } field_sel_t;

endpackage

// File: rtl/psr_operand_sel.sv
module psr_operand_sel #(
   parameter int XLEN      = 32,
   parameter int IMM_W     = 8,
   parameter int ROT_W     = 4,
   parameter int ROT_STYLE = 0
) (
   input  logic             use_imm,
   input  logic [IMM_W-1:0] imm_field,
   input  logic [ROT_W-1:0] rot_field,
   input  logic [XLEN-1:0]  src_data,
   output logic [XLEN-1:0]  operand
);
   localparam int AMT_W = ROT_W + 1;

   logic [AMT_W-1:0] amt;
   logic [XLEN-1:0]  imm_ext;
   logic [XLEN-1:0]  rotated;

   assign amt     = {rot_field, 1'b0};
   assign imm_ext = {{(XLEN-IMM_W){1'b0}}, imm_field};

   generate
      if ((2 ** AMT_W) > 2 * XLEN) begin : g_bad_rot
         $error("psr_operand_sel: rotate range exceeds word width");
      end
      if (IMM_W > XLEN) begin : g_bad_imm
         $error("psr_operand_sel: immediate wider than word");
      end

      if (ROT_STYLE == 0) begin : g_rot_dbl
         // double-width funnel: one wide shifter
         logic [2*XLEN-1:0] dbl;
         assign dbl     = {imm_ext, imm_ext} >> amt;
         assign rotated = dbl[XLEN-1:0];
      end else begin : g_rot_log
         // logarithmic stages, one per amount bit
         logic [XLEN-1:0] stg [0:AMT_W];
         assign stg[0] = imm_ext;
         for (genvar s = 0; s < AMT_W; s++) begin : g_stage
            assign stg[s+1] = amt[s]
               ? {stg[s][(2**s)-1:0], stg[s][XLEN-1:(2**s)]}
               : stg[s];
         end
         assign rotated = stg[AMT_W];
      end
   endgenerate

   assign operand = use_imm ? rotated : src_data;

endmodule

// File: rtl/psr_mask_gen.sv
module psr_mask_gen
   import psr_pkg::*;
#(
   parameter int          XLEN       = 32,
   parameter logic [31:0] FLAG_BITS  = FLAG_BITS_DEF,
   parameter logic [31:0] PRIV_BITS  = PRIV_BITS_DEF,
   parameter logic [31:0] STATE_BITS = STATE_BITS_DEF
) (
   input  field_sel_t      sel,
   input  logic            is_user,
   output logic [XLEN-1:0] cur_mask,
   output logic [XLEN-1:0] saved_mask
);
   localparam logic [XLEN-1:0] LOW_BYTE  = {{(XLEN-8){1'b0}}, 8'hFF};
   localparam logic [XLEN-1:0] TOP_BYTE  = {8'hFF, {(XLEN-8){1'b0}}};
   localparam logic [XLEN-1:0] FLAG_M    = FLAG_BITS[XLEN-1:0];
   localparam logic [XLEN-1:0] PRIV_M    = PRIV_BITS[XLEN-1:0];
   localparam logic [XLEN-1:0] STATE_M   = STATE_BITS[XLEN-1:0];
   localparam logic [XLEN-1:0] ALL_PROT  = FLAG_M | PRIV_M | STATE_M;

   generate
      if (((FLAG_BITS & PRIV_BITS) | (FLAG_BITS & STATE_BITS) |
           (PRIV_BITS & STATE_BITS)) != 32'h0) begin : g_overlap
         $error("psr_mask_gen: protection groups overlap");
      end
      if (XLEN != 32) begin : g_width
         $error("psr_mask_gen: status word must be 32 bits");
      end
   endgenerate

   logic [XLEN-1:0] byte_sel;
   logic [XLEN-1:0] flag_part;
   logic [XLEN-1:0] state_part;
   logic [XLEN-1:0] priv_part;

   always_comb begin
      byte_sel   = (sel.top_sel ? TOP_BYTE : '0) | (sel.low_sel ? LOW_BYTE : '0);
      flag_part  = sel.top_sel ? (FLAG_M & TOP_BYTE) : '0;
      state_part = sel.low_sel ? (STATE_M & LOW_BYTE) : '0;
      priv_part  = (sel.low_sel && !is_user) ? (PRIV_M & LOW_BYTE) : '0;
      cur_mask   = flag_part | state_part | priv_part;
      saved_mask = byte_sel & ALL_PROT;
   end

endmodule

// File: rtl/psr_readback.sv
module psr_readback #(
   parameter int XLEN  = 32,
   parameter int IDX_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_req,
   input  logic             rd_saved,
   input  logic [IDX_W-1:0] dest,
   input  logic [XLEN-1:0]  cur_word,
   input  logic [XLEN-1:0]  saved_word,
   output logic             rd_valid,
   output logic [IDX_W-1:0] rd_dest,
   output logic [XLEN-1:0]  rd_data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_dest  <= '0;
         rd_data  <= '0;
      end else begin
         rd_valid <= rd_req;
         if (rd_req) begin
            rd_dest <= dest;
            rd_data <= rd_saved ? saved_word : cur_word;
         end
      end
   end

   // R9: a read yields exactly one valid pulse in the next cycle
   a_r9_read_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> rd_valid);
   a_r9_no_spurious : assert property (@(posedge clk) disable iff (!rst_n)
      !rd_req |=> !rd_valid);

endmodule

// File: rtl/psr_write_unit.sv
module psr_write_unit
   import psr_pkg::*;
#(
   parameter int          XLEN        = 32,
   parameter int          IDX_W       = 4,
   parameter int          MODE_W      = 5,
   parameter int          IMM_W       = 8,
   parameter int          ROT_W       = 4,
   parameter int          ROT_STYLE   = 0,
   parameter logic [4:0]  USER_MODE   = 5'h10,
   parameter int          FORCE_BIT   = 4,
   parameter logic [31:0] CUR_RESET   = 32'h0000_00D3,
   parameter logic [31:0] SAVED_RESET = 32'h0000_0010,
   parameter logic [31:0] FLAG_BITS   = FLAG_BITS_DEF,
   parameter logic [31:0] PRIV_BITS   = PRIV_BITS_DEF,
   parameter logic [31:0] STATE_BITS  = STATE_BITS_DEF
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             req_saved,
   input  logic             req_imm,
   input  logic [31:0]      instr,
   output logic [IDX_W-1:0] src_idx,
   input  logic [XLEN-1:0]  src_data,
   output logic [XLEN-1:0]  cur_psr,
   output logic [XLEN-1:0]  saved_psr,
   output logic [MODE_W-1:0] mode_out,
   output logic             flush_req,
   output logic             rd_valid,
   output logic [IDX_W-1:0] rd_dest,
   output logic [XLEN-1:0]  rd_data
);
   localparam logic [XLEN-1:0] FORCE_M  = XLEN'(1) << FORCE_BIT;
   localparam logic [XLEN-1:0] WRITABLE = FLAG_BITS | PRIV_BITS | STATE_BITS;

   generate
      if (MODE_W > 5 || MODE_W < 1) begin : g_mode_w
         $error("psr_write_unit: mode field width out of range");
      end
      if (FORCE_BIT >= XLEN) begin : g_force
         $error("psr_write_unit: forced bit outside word");
      end
   endgenerate

   logic [XLEN-1:0] cur_q, saved_q;
   logic [XLEN-1:0] operand;
   logic [XLEN-1:0] cur_mask, saved_mask;
   logic            is_user;
   logic            wr_cur, wr_sav, rd_req;
   field_sel_t      sel;
   logic            unused_instr_bits;

   assign unused_instr_bits = ^{instr[31:20], instr[18:17]};

   assign wr_cur  = req_valid &  req_write & !req_saved;
   assign wr_sav  = req_valid &  req_write &  req_saved;
   assign rd_req  = req_valid & !req_write;
   assign sel     = '{top_sel: instr[TOP_SEL_POS], low_sel: instr[LOW_SEL_POS]};
   assign src_idx = instr[SRC_LSB +: IDX_W];
   assign is_user = (cur_q[MODE_W-1:0] == USER_MODE[MODE_W-1:0]);

   psr_operand_sel #(
      .XLEN(XLEN), .IMM_W(IMM_W), .ROT_W(ROT_W), .ROT_STYLE(ROT_STYLE)
   ) u_operand (
      .use_imm  (req_imm),
      .imm_field(instr[IMM_LSB +: IMM_W]),
      .rot_field(instr[ROT_LSB +: ROT_W]),
      .src_data (src_data),
      .operand  (operand)
   );

   psr_mask_gen #(
      .XLEN(XLEN), .FLAG_BITS(FLAG_BITS), .PRIV_BITS(PRIV_BITS),
      .STATE_BITS(STATE_BITS)
   ) u_masks (
      .sel       (sel),
      .is_user   (is_user),
      .cur_mask  (cur_mask),
      .saved_mask(saved_mask)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q     <= CUR_RESET[XLEN-1:0];
         saved_q   <= SAVED_RESET[XLEN-1:0];
         flush_req <= 1'b0;
      end else begin
         flush_req <= wr_cur;
         if (wr_cur) begin
            cur_q <= (cur_q & ~cur_mask) | (operand & cur_mask);
         end
         if (wr_sav) begin
            saved_q <= (saved_q & ~saved_mask) | (operand & saved_mask) | FORCE_M;
         end
      end
   end

   psr_readback #(.XLEN(XLEN), .IDX_W(IDX_W)) u_read (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_req    (rd_req),
      .rd_saved  (req_saved),
      .dest      (instr[DEST_LSB +: IDX_W]),
      .cur_word  (cur_q),
      .saved_word(saved_q),
      .rd_valid  (rd_valid),
      .rd_dest   (rd_dest),
      .rd_data   (rd_data)
   );

   assign cur_psr   = cur_q;
   assign saved_psr = saved_q;
   assign mode_out  = cur_q[MODE_W-1:0];

   // R4: bits outside every protection group never move
   a_r4_fixed_bits : assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(cur_q & ~WRITABLE));
   // R4: flags hold unless the top byte is written
   a_r4_flags_hold : assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_cur && sel.top_sel) |=> $stable(cur_q & FLAG_BITS));
   // R6: user mode guards the privileged bits of the current word
   a_r6_user_guard : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cur && is_user) |=> $stable(cur_q & PRIV_BITS));
   // R7: privileged control write sets the new mode
   a_r7_mode_update : assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cur && sel.low_sel && !is_user) |=>
         (mode_out[3:0] == $past(operand[3:0])) && mode_out[MODE_W-1]);
   // R8: saved word always carries the forced bit after a write
   a_r8_saved_force : assert property (@(posedge clk) disable iff (!rst_n)
      wr_sav |=> saved_psr[FORCE_BIT]);
   // R9: reads leave both words untouched
   a_r9_read_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> ($stable(cur_psr) && $stable(saved_psr)));
   // R10: no flush without a current-word write
   a_r10_flush_cause : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_cur |=> !flush_req);

endmodule

// File: tb/test_psr_write_unit.sv
module test_psr_write_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_saved = 1'b0, req_imm = 1'b0;
   logic [31:0] instr = '0;
   logic [3:0]  src_idx;
   logic [31:0] src_data = '0;
   logic [31:0] cur_psr, saved_psr, rd_data;
   logic [4:0]  mode_out;
   logic        flush_req, rd_valid;
   logic [3:0]  rd_dest;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [31:0] exp_cur, exp_saved;

   always #4 clk = ~clk;   // 125 MHz

   psr_write_unit i_psr_write_unit (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_saved(req_saved), .req_imm(req_imm), .instr(instr),
      .src_idx(src_idx), .src_data(src_data), .cur_psr(cur_psr),
      .saved_psr(saved_psr), .mode_out(mode_out), .flush_req(flush_req),
      .rd_valid(rd_valid), .rd_dest(rd_dest), .rd_data(rd_data)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] mk(input bit top, input bit low, input logic [3:0] dest,
                                      input logic [3:0] rot, input logic [7:0] imm);
      return {12'h000, top, 2'b00, low, dest, rot, imm};
   endfunction

   function automatic logic [31:0] ror_ref(input logic [7:0] imm, input logic [3:0] rot);
      logic [31:0] v = {24'h0, imm};
      for (int i = 0; i < 2 * rot; i++) v = {v[0], v[31:1]};
      return v;
   endfunction

   // expected current word from the requirement text
   function automatic logic [31:0] ref_cur(input logic [31:0] old, input logic [31:0] op,
                                           input bit top, input bit low);
      logic [31:0] m = 32'h0;
      if (top) m |= 32'hF000_0000;
      if (low) m |= 32'h0000_0020;
      if (low && old[4:0] != 5'h10) m |= 32'h0000_00CF;
      return (old & ~m) | (op & m);
   endfunction

   function automatic logic [31:0] ref_saved(input logic [31:0] old, input logic [31:0] op,
                                             input bit top, input bit low);
      logic [31:0] m = 32'h0;
      if (top) m |= 32'hF000_0000;
      if (low) m |= 32'h0000_00EF;
      return (old & ~m) | (op & m) | 32'h10;
   endfunction

   task automatic issue(input bit wr, input bit sav, input bit imm, input logic [31:0] ins,
                        input logic [31:0] src);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_saved = sav; req_imm = imm;
      instr = ins; src_data = src;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0; req_saved = 1'b0; req_imm = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      exp_cur = 32'h0000_00D3; exp_saved = 32'h0000_0010;
      chk("R1 cur reset", cur_psr, exp_cur);
      chk("R1 saved reset", saved_psr, exp_saved);
      chk("R1 mode reset", {27'h0, mode_out}, 32'h13);
      chk("R1 flush reset", {31'h0, flush_req}, 32'h0);
      chk("R1 rd_valid reset", {31'h0, rd_valid}, 32'h0);
   endtask

   task automatic t_imm_flags();
      logic [31:0] op;
      // R2 R4: even rotate, flags only
      op = ror_ref(8'h0F, 4'h2);
      issue(1, 0, 1, mk(1, 0, 4'h0, 4'h2, 8'h0F), 32'h0);
      exp_cur = ref_cur(exp_cur, op, 1, 0);
      chk("R4 flags write", cur_psr, exp_cur);
      chk("R4 flags literal", cur_psr, 32'hF000_00D3);
      chk("R10 flush after write", {31'h0, flush_req}, 32'h1);
      @(negedge clk);
      chk("R10 flush one cycle", {31'h0, flush_req}, 32'h0);
      // R2: odd rotate field means a rotate by twice its value
      op = ror_ref(8'hAB, 4'h1);
      issue(1, 0, 1, mk(1, 0, 4'h0, 4'h1, 8'hAB), 32'h0);
      exp_cur = ref_cur(exp_cur, op, 1, 0);
      chk("R2 odd rotate", cur_psr, 32'hC000_00D3);
   endtask

   task automatic t_reg_ctrl();
      logic [31:0] ins;
      ins = mk(0, 1, 4'h0, 4'h0, 8'h05);
      @(negedge clk);
      instr = ins;
      #1 chk("R3 src index", {28'h0, src_idx}, 32'h5);
      issue(1, 0, 0, ins, 32'h7777_7F1F);
      exp_cur = ref_cur(exp_cur, 32'h7777_7F1F, 0, 1);
      chk("R5 control write", cur_psr, exp_cur);
      chk("R7 mode after write", {27'h0, mode_out}, 32'h1F);
      // both bytes, flags cleared, mode 0x12
      issue(1, 0, 0, mk(1, 1, 4'h0, 4'h0, 8'h03), 32'h0FFF_FF32);
      exp_cur = ref_cur(exp_cur, 32'h0FFF_FF32, 1, 1);
      chk("R4 R5 both bytes", cur_psr, 32'h0000_0032);
      chk("R7 mode 0x12", {27'h0, mode_out}, 32'h12);
      // no field selected: nothing changes but flush still rises
      issue(1, 0, 0, mk(0, 0, 4'h0, 4'h0, 8'h01), 32'hFFFF_FFFF);
      chk("R4 no field no change", cur_psr, exp_cur);
      chk("R10 flush with empty select", {31'h0, flush_req}, 32'h1);
   endtask

   task automatic t_saved();
      issue(1, 1, 0, mk(1, 1, 4'h0, 4'h0, 8'h02), 32'hFFFF_FFFF);
      exp_saved = ref_saved(exp_saved, 32'hFFFF_FFFF, 1, 1);
      chk("R8 saved all ones", saved_psr, 32'hF000_00FF);
      chk("R10 no flush on saved write", {31'h0, flush_req}, 32'h0);
      chk("R8 current untouched", cur_psr, exp_cur);
      issue(1, 1, 0, mk(0, 1, 4'h0, 4'h0, 8'h02), 32'h0);
      exp_saved = ref_saved(exp_saved, 32'h0, 0, 1);
      chk("R8 saved forced bit", saved_psr, 32'hF000_0010);
   endtask

   task automatic t_read();
      issue(0, 0, 0, mk(0, 0, 4'hA, 4'h0, 8'h00), 32'h0);
      chk("R9 rd_valid", {31'h0, rd_valid}, 32'h1);
      chk("R9 rd_dest", {28'h0, rd_dest}, 32'hA);
      chk("R9 rd_data current", rd_data, exp_cur);
      chk("R10 no flush on read", {31'h0, flush_req}, 32'h0);
      issue(0, 1, 0, mk(1, 1, 4'h3, 4'h0, 8'h00), 32'hFFFF_FFFF);
      chk("R9 rd_data saved", rd_data, exp_saved);
      chk("R9 rd_dest saved", {28'h0, rd_dest}, 32'h3);
      chk("R9 saved unchanged by read", saved_psr, exp_saved);
      chk("R9 current unchanged by read", cur_psr, exp_cur);
      @(negedge clk);
      chk("R9 rd_valid drops", {31'h0, rd_valid}, 32'h0);
   endtask

   task automatic t_user();
      issue(1, 0, 0, mk(0, 1, 4'h0, 4'h0, 8'h00), 32'h0000_0010);
      exp_cur = ref_cur(exp_cur, 32'h10, 0, 1);
      chk("R7 enter user mode", {27'h0, mode_out}, 32'h10);
      issue(1, 0, 0, mk(1, 1, 4'h0, 4'h0, 8'h00), 32'hF000_00EF);
      exp_cur = ref_cur(exp_cur, 32'hF000_00EF, 1, 1);
      chk("R6 user partial write", cur_psr, 32'hF000_0030);
      chk("R6 mode stays user", {27'h0, mode_out}, 32'h10);
      issue(1, 1, 1, mk(0, 1, 4'h0, 4'h0, 8'hC3), 32'h0);
      exp_saved = ref_saved(exp_saved, 32'hC3, 0, 1);
      chk("R8 saved write in user mode", saved_psr, exp_saved);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      do_reset();
      t_imm_flags();
      t_reg_ctrl();
      t_saved();
      t_read();
      t_user();
      do_reset();
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule